// File: doc/BRIEF.md
# Full-Speed USB Line Receiver

This block turns a sampled full-speed USB differential pair into packet bytes. A recovery stage in front of it delivers D+ and D- already synchronised and aligned to bit centres, and raises a one-clock bit strobe once per bit time. On each strobe the receiver classifies the pair as J, K, SE0 or the invalid both-high state. While idle it searches for the sync pattern. Inside a packet it decodes NRZI, drops stuffed zeros and packs the payload least significant bit first.

Outputs are one-clock pulses: a byte with its valid strobe, packet start, packet end and error. A separate level output reports a bus reset, which is an SE0 held for a programmable number of bit times. CRC and PID handling belong to later stages. After a packet end or any error the receiver goes back to searching for sync.

Top module: `usbfs_line_rx`

## Requirements
- R1: On a strobe the pair {dp_i,dn_i} is classified as follows: 2'b10 is J, 2'b01 is K, 2'b00 is SE0 and 2'b11 is invalid.
- R2: While searching, at least six consecutive J/K changes followed by a repeated K produce pkt_start_o. That final K counts as the first 1 of the packet for the stuffing rule.
- R3: Inside a packet a J/K sample equal to the previous J/K sample decodes as 1, and a changed sample decodes as 0.
- R4: Every eight payload bits give one byte_valid_o pulse. The first bit received lands in byte_o[0].
- R5: After six consecutive decoded 1s the next bit, a 0, is dropped and is not added to any byte.
- R6: A seventh consecutive 1 that is followed by a J or K sample raises err_o with no pkt_end_o.
- R7: A seventh consecutive 1 that is followed directly by SE0 is discarded: the packet ends without error and the bit is not counted.
- R8: SE0, SE0, J ends a packet with pkt_end_o. A single SE0 followed by J or K raises err_o instead.
- R9: If the payload bit count is not a multiple of eight at packet end, err_o pulses together with pkt_end_o.
- R10: The both-high state raises err_o on the next clock, whether in a packet or while searching.
- R11: bus_reset_o rises on the RESET_BITS-th consecutive SE0 strobe and falls on the first strobe that is not SE0.
- R12: After packet end or an error, no byte_valid_o appears until a new sync is seen.
- R13: The pulse outputs are registered and last one clock. They appear only in the clock after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bit_en_i | input | 1 | one-clock strobe per bit time |
| dp_i | input | 1 | sampled D+ level |
| dn_i | input | 1 | sampled D- level |
| byte_o | output | 8 | received byte |
| byte_valid_o | output | 1 | byte_o is valid this clock |
| pkt_start_o | output | 1 | sync found |
| pkt_end_o | output | 1 | end of packet seen |
| err_o | output | 1 | stuffing, line-state or framing error |
| bus_reset_o | output | 1 | prolonged SE0 reported |

## Verification
The hardest case is a seventh 1 that arrives right before the end-of-packet SE0. The port sequence has to reach exactly six ones with no stuffed zero and then add one more unchanged sample. The bench therefore sends that byte as raw line levels with its own stuffing turned off. It then sends a second run that ends in a line change instead of SE0, which must produce the error. The sync-relative stuffing count is also exercised, by a payload of all ones that needs stuffing after five data bits.

// File: rtl/usbfs_rx_pkg.sv
`timescale 1ns/1ps
package usbfs_rx_pkg;
  // encoding equals {dp, dn}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DATA,
    ST_PEND,
    ST_EOP1,
    ST_EOP2
  } rx_st_t;
endpackage

// File: rtl/usbfs_line_class.sv
`timescale 1ns/1ps
module usbfs_line_class
  import usbfs_rx_pkg::*;
(
  input  logic  dp_i,
  input  logic  dn_i,
  output line_t ls_o
);
  always_comb begin
    unique case ({dp_i, dn_i})
      2'b10:   ls_o = LS_J;
      2'b01:   ls_o = LS_K;
      2'b00:   ls_o = LS_SE0;
      default: ls_o = LS_SE1;
    endcase
  end
endmodule

// File: rtl/usbfs_byte_asm.sv
`timescale 1ns/1ps
module usbfs_byte_asm #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o,
  output logic         valid_o,
  output logic         aligned_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  shreg_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shreg_d;

  assign shreg_d   = {bit_i, shreg_q[W-1:1]};
  assign aligned_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (push_i) begin
        shreg_q <= shreg_d;
        if (cnt_q == CW'(W - 1)) begin
          byte_o  <= shreg_d;
          valid_o <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usbfs_bus_reset_det.sv
`timescale 1ns/1ps
module usbfs_bus_reset_det #(
  parameter int LIMIT = 120000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic se0_i,
  output logic reset_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (cnt_q == CW'(LIMIT)) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      reset_o <= 1'b0;
    end else if (bit_en_i) begin
      if (se0_i) begin
        cnt_q   <= cnt_inc;
        reset_o <= (cnt_inc >= CW'(LIMIT));
      end else begin
        cnt_q   <= '0;
        reset_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbfs_line_rx.sv
`timescale 1ns/1ps
module usbfs_line_rx
  import usbfs_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SYNC_ZEROS = 6,
  parameter int STUFF_RUN  = 6,
  parameter int RESET_BITS = 120000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              dp_i,
  input  logic              dn_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              pkt_start_o,
  output logic              pkt_end_o,
  output logic              err_o,
  output logic              bus_reset_o
);
  localparam int ZW = $clog2(SYNC_ZEROS + 2);
  localparam int OW = $clog2(STUFF_RUN + 1);

  line_t   ls;
  rx_st_t  st_q, st_d;
  line_t   prev_q, prev_d;
  logic [ZW-1:0] zcnt_q, zcnt_d;
  logic [OW-1:0] ones_q, ones_d;
  logic    start_d, end_d, err_d;
  logic    push, clr, same, aligned;

  usbfs_line_class u_class (.dp_i(dp_i), .dn_i(dn_i), .ls_o(ls));

  usbfs_byte_asm #(.W(BYTE_W)) u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .push_i(push), .bit_i(same),
    .byte_o(byte_o), .valid_o(byte_valid_o), .aligned_o(aligned)
  );

  usbfs_bus_reset_det #(.LIMIT(RESET_BITS)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .se0_i(ls == LS_SE0), .reset_o(bus_reset_o)
  );

  assign same = (ls == prev_q);

  always_comb begin
    st_d    = st_q;
    prev_d  = prev_q;
    zcnt_d  = zcnt_q;
    ones_d  = ones_q;
    start_d = 1'b0;
    end_d   = 1'b0;
    err_d   = 1'b0;
    push    = 1'b0;
    clr     = 1'b0;
    if (bit_en_i) begin
      // SE0/SE1 leave idle J as the reference level
      prev_d = (ls == LS_J || ls == LS_K) ? ls : LS_J;
      unique case (st_q)
        ST_HUNT: begin
          if (ls == LS_J || ls == LS_K) begin
            if (!same) begin
              if (zcnt_q != ZW'(SYNC_ZEROS + 1)) zcnt_d = zcnt_q + 1'b1;
            end else if (ls == LS_K && zcnt_q >= ZW'(SYNC_ZEROS)) begin
              start_d = 1'b1;
              clr     = 1'b1;
              ones_d  = OW'(1);
              zcnt_d  = '0;
              st_d    = ST_DATA;
            end else begin
              zcnt_d = '0;
            end
          end else begin
            zcnt_d = '0;
            err_d  = (ls == LS_SE1);
          end
        end
        ST_DATA: begin
          if (ls == LS_SE1) begin
            err_d = 1'b1;
            st_d  = ST_HUNT;
          end else if (ls == LS_SE0) begin
            st_d = ST_EOP1;
          end else if (ones_q == OW'(STUFF_RUN)) begin
            if (!same) ones_d = '0;   // stuffed zero, dropped
            else       st_d   = ST_PEND;
          end else begin
            push   = 1'b1;
            ones_d = same ? ones_q + 1'b1 : '0;
          end
        end
        ST_PEND: begin
          // seventh one: only tolerated as skew right before SE0
          if (ls == LS_SE0) st_d = ST_EOP1;
          else begin
            err_d = 1'b1;
            st_d  = ST_HUNT;
          end
        end
        ST_EOP1: begin
          if (ls == LS_SE0) st_d = ST_EOP2;
          else begin
            err_d = 1'b1;
            st_d  = ST_HUNT;
          end
        end
        ST_EOP2: begin
          if (ls == LS_J) begin
            end_d = 1'b1;
            err_d = !aligned;
            st_d  = ST_HUNT;
          end else if (ls != LS_SE0) begin
            err_d = 1'b1;
            st_d  = ST_HUNT;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_HUNT;
      prev_q      <= LS_J;
      zcnt_q      <= '0;
      ones_q      <= '0;
      pkt_start_o <= 1'b0;
      pkt_end_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      st_q        <= st_d;
      prev_q      <= prev_d;
      zcnt_q      <= zcnt_d;
      ones_q      <= ones_d;
      pkt_start_o <= start_d;
      pkt_end_o   <= end_d;
      err_o       <= err_d;
    end
  end
endmodule

// File: rtl/usbfs_line_rx_chk.sv
`timescale 1ns/1ps
module usbfs_line_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic dp_i,
  input logic dn_i,
  input logic byte_valid_o,
  input logic pkt_start_o,
  input logic pkt_end_o,
  input logic err_o,
  input logic bus_reset_o
);
  p_pulse_after_strobe_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o || pkt_start_o || pkt_end_o || err_o) |-> $past(bit_en_i));

  p_start_on_k_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> $past(!dp_i && dn_i));

  p_end_on_j_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> $past(dp_i && !dn_i));

  p_start_end_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_start_o && pkt_end_o));

  p_se1_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && dp_i && dn_i) |=> err_o);

  p_reset_rise_se0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_reset_o) |-> $past(bit_en_i && !dp_i && !dn_i));

  p_no_byte_at_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> !byte_valid_o);
endmodule

bind usbfs_line_rx usbfs_line_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .dp_i(dp_i), .dn_i(dn_i),
  .byte_valid_o(byte_valid_o), .pkt_start_o(pkt_start_o), .pkt_end_o(pkt_end_o),
  .err_o(err_o), .bus_reset_o(bus_reset_o)
);

// File: tb/usbfs_line_rx_test.sv
`timescale 1ns/1ps
module usbfs_line_rx_test;
  localparam int RST_N = 20;
  localparam logic [1:0] J = 2'b10, K = 2'b01, Z = 2'b00, X = 2'b11;

  logic clk_i = 1'b0, rst_ni = 1'b0, bit_en_i = 1'b0, dp_i = 1'b1, dn_i = 1'b0;
  logic [7:0] byte_o;
  logic byte_valid_o, pkt_start_o, pkt_end_o, err_o, bus_reset_o;

  int checks = 0, fails = 0;
  int n_bytes, n_start, n_end, n_err, n_end_err;
  logic [7:0] got [0:15];
  logic [1:0] lvl;
  int ones;

  always #2.5 clk_i = ~clk_i;

  usbfs_line_rx #(.RESET_BITS(RST_N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .dp_i(dp_i), .dn_i(dn_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .pkt_start_o(pkt_start_o),
    .pkt_end_o(pkt_end_o), .err_o(err_o), .bus_reset_o(bus_reset_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_bytes = 0; n_start = 0; n_end = 0; n_err = 0; n_end_err = 0;
  endtask

  task automatic send(input logic [1:0] s);
    @(negedge clk_i);
    {dp_i, dn_i} = s;
    bit_en_i = 1'b1;
    @(negedge clk_i);
    bit_en_i = 1'b0;
    if (byte_valid_o) begin
      if (n_bytes < 16) got[n_bytes] = byte_o;
      n_bytes++;
    end
    n_start += int'(pkt_start_o);
    n_end   += int'(pkt_end_o);
    n_err   += int'(err_o);
    if (pkt_end_o && err_o) n_end_err++;
    @(negedge clk_i);
  endtask

  task automatic tx_raw(input bit b);
    if (!b) lvl = (lvl == J) ? K : J;
    send(lvl);
  endtask

  task automatic tx_bit(input bit b);
    tx_raw(b);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin
      tx_raw(1'b0);
      ones = 0;
    end
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_bit(v[i]);
  endtask

  task automatic idle(input int n);
    lvl = J;
    for (int i = 0; i < n; i++) send(J);
  endtask

  task automatic tx_sync();
    idle(3);
    for (int i = 0; i < 7; i++) tx_raw(1'b0);
    tx_raw(1'b1);
    ones = 1;
  endtask

  task automatic tx_eop();
    send(Z); send(Z); send(J);
    lvl = J;
  endtask

  task automatic t_reset();
    chk(byte_valid_o == 0 && pkt_start_o == 0 && pkt_end_o == 0 && err_o == 0,
        "R13 reset pulses", {byte_valid_o, pkt_start_o, pkt_end_o, err_o}, 0);
    chk(bus_reset_o == 0, "R11 reset level", bus_reset_o, 0);
  endtask

  task automatic t_basic();
    clr_mon();
    tx_sync();
    chk(n_start == 1, "R2 sync start", n_start, 1);
    tx_byte(8'hA5); tx_byte(8'h3C);
    tx_eop();
    chk(n_bytes == 2, "R4 byte count", n_bytes, 2);
    chk(got[0] == 8'hA5, "R3 R4 first byte", got[0], 8'hA5);
    chk(got[1] == 8'h3C, "R3 R4 second byte", got[1], 8'h3C);
    chk(n_end == 1 && n_err == 0, "R8 clean end", n_end * 10 + n_err, 10);
    clr_mon();
    for (int i = 0; i < 10; i++) tx_raw(i[0]);
    chk(n_bytes == 0 && n_start == 0, "R12 hunt after end", n_bytes, 0);
  endtask

  task automatic t_stuff();
    clr_mon();
    tx_sync();
    tx_byte(8'hFF); tx_byte(8'hFF); tx_byte(8'h7E);
    tx_eop();
    chk(n_bytes == 3, "R5 stuffed byte count", n_bytes, 3);
    chk(got[0] == 8'hFF && got[1] == 8'hFF, "R5 stuffed payload", {got[0], got[1]}, 16'hFFFF);
    chk(got[2] == 8'h7E, "R5 after stuffing", got[2], 8'h7E);
    chk(n_err == 0 && n_end == 1, "R5 no error", n_err, 0);
  endtask

  task automatic t_seven();
    clr_mon();
    tx_sync();
    for (int i = 0; i < 6; i++) tx_raw(1'b1);
    tx_raw(1'b0);
    chk(n_err == 1 && n_end == 0, "R6 seven ones", n_err, 1);
    clr_mon();
    for (int i = 0; i < 8; i++) tx_raw(i[1]);
    tx_eop();
    chk(n_bytes == 0 && n_end == 0, "R12 no bytes after error", n_bytes, 0);
  endtask

  task automatic t_skew();
    clr_mon();
    tx_sync();
    tx_raw(1'b0); tx_raw(1'b0);
    for (int i = 0; i < 6; i++) tx_raw(1'b1);
    tx_raw(1'b1);
    tx_eop();
    chk(n_bytes == 1 && got[0] == 8'hFC, "R7 skew byte", got[0], 8'hFC);
    chk(n_end == 1 && n_err == 0, "R7 skew bit ignored", n_end * 10 + n_err, 10);
  endtask

  task automatic t_misalign();
    clr_mon();
    tx_sync();
    tx_byte(8'hA5);
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    tx_eop();
    chk(n_bytes == 1, "R9 whole bytes", n_bytes, 1);
    chk(n_end_err == 1, "R9 error with end", n_end_err, 1);
  endtask

  task automatic t_se1();
    clr_mon();
    tx_sync();
    tx_byte(8'h12);
    send(X);
    chk(n_err == 1, "R10 invalid in packet", n_err, 1);
    tx_eop();
    chk(n_end == 0, "R10 R12 no end after error", n_end, 0);
    clr_mon();
    idle(2);
    send(X);
    chk(n_err == 1, "R10 invalid while idle", n_err, 1);
    chk(n_start == 0 && n_bytes == 0, "R1 invalid no start", n_start, 0);
  endtask

  task automatic t_single_se0();
    clr_mon();
    tx_sync();
    tx_byte(8'h55);
    send(Z); send(J);
    chk(n_err == 1 && n_end == 0, "R8 single SE0", n_err, 1);
  endtask

  task automatic t_bus_reset();
    idle(2);
    for (int i = 0; i < RST_N - 1; i++) send(Z);
    chk(bus_reset_o == 0, "R11 below limit", bus_reset_o, 0);
    send(Z);
    chk(bus_reset_o == 1, "R11 at limit", bus_reset_o, 1);
    send(Z);
    chk(bus_reset_o == 1, "R11 held", bus_reset_o, 1);
    send(J);
    chk(bus_reset_o == 0, "R11 released", bus_reset_o, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    lvl = J; ones = 0;
    clr_mon();
    repeat (4) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_basic();
    t_stuff();
    t_seven();
    t_skew();
    t_misalign();
    t_se1();
    t_single_se0();
    t_bus_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule